// File: doc/BRIEF.md
# Configuration frame address sequencer

This block keeps the 32-bit address of the configuration frame currently being written and moves it forward as configuration words arrive. A parent block first loads a starting address with a one-cycle write strobe. After that, each accepted data word is counted. Once a full frame of `WORDS_PER_FRAME` words (101 by default) has been accepted, the block reports a completed frame. It then steps the address to the next minor frame, and carries into the column, row and half fields when those wrap. When a row finishes, the block announces that `PAD_FRAMES` (two by default) all-zero filler frames must come next. The address does not move while those filler frames are taken.

A column does not always hold the same number of frames. The block presents `{bus, column}` of the current address on a lookup output. The parent answers combinationally with the frame count for that column. Software can set a hold control so that the address stays fixed across several frames. A write burst whose final word does not complete a frame raises a sticky error.

The control has three states: `S_IDLE` (no address loaded yet, words are ignored), `S_DATA` (frames advance the address) and `S_PAD` (filler frames are counted and the address holds). The transitions are as follows:
- `S_IDLE` goes to `S_DATA` on a load.
- `S_DATA` goes to `S_PAD` when a frame completes with auto-increment on and the column wraps.
- `S_PAD` goes to `S_DATA` when the last filler frame completes.
- Any state goes to `S_DATA` on a load.

Top module: `frame_addr_seq`

## Requirements
- R1: After reset `frame_addr` is 0 and `frame_done`, `expect_pad` and `short_err` are 0. Data words that arrive before the first address load are ignored and never produce `frame_done`.
- R2: When `far_wr` is high, `far_wdata` appears on `frame_addr` one cycle later and the word count restarts at zero. A data word in the same cycle as `far_wr` is discarded.
- R3: `frame_done` is high for exactly one cycle, in the cycle after the `WORDS_PER_FRAME`-th accepted word of a frame.
- R4: Address layout: bits 6:0 minor, 16:7 column, 21:17 row, 22 half, 25:23 bus, 31:26 reserved. `cnt_idx` is `{frame_addr[25:23], frame_addr[16:7]}`. On a completed frame with auto-increment on, minor increments, or it wraps to 0 when minor+1 is at least `cnt_frames`.
- R5: When minor wraps and the column is at or above `COL_LAST`, the column goes to 0 and the row increments. The bus and reserved fields never change except on a load.
- R6: When the column wraps and the row is at or above `ROW_LAST`, the row goes to 0 and the half bit toggles.
- R7: After a frame that wraps the column, `expect_pad` is 1 from the following cycle on. The next `PAD_FRAMES` completed frames leave the address unchanged, and `expect_pad` falls together with the `frame_done` of the last filler frame.
- R8: With `autoinc_off` high on the completing word, the address stays unchanged and no filler frames are requested.
- R9: `short_err` becomes 1 in the cycle after a word with `data_last` high that is not the last word of a frame, stays 1, and clears only on a load. `data_last` on a frame's last word raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| far_wr | input | 1 | Load strobe for the start address |
| far_wdata | input | 32 | Start address to load |
| data_vld | input | 1 | One configuration word accepted this cycle |
| data_last | input | 1 | Marks the final word of a write burst |
| autoinc_off | input | 1 | Holds the address across completed frames |
| cnt_idx | output | 13 | Lookup index `{bus, column}` of the current address |
| cnt_frames | input | 7 | Frame count of the indexed column |
| frame_done | output | 1 | One-cycle pulse per completed frame |
| frame_addr | output | 32 | Current frame address |
| expect_pad | output | 1 | Filler frames are due |
| short_err | output | 1 | Sticky short-final-frame error |

## Verification
Two functions can land on the same edge: an address load and an incoming data word. The load must win, the counter must restart and the word must vanish. The bench provokes this by raising `far_wr` and `data_vld` together. It then checks that `WORDS_PER_FRAME`-1 further words give no `frame_done` and that one more word gives it. A second coincidence is a frame end that is also a column, row and half wrap with a filler request. The bench judges this from the address fields and `expect_pad` in the cycle of that `frame_done`.

// File: rtl/far_pkg.sv
package far_pkg;
    localparam int MINOR_W = 7;
    localparam int COL_W   = 10;
    localparam int ROW_W   = 5;
    localparam int BUS_W   = 3;
    localparam int RSV_W   = 6;
    localparam int IDX_W   = BUS_W + COL_W;

    typedef struct packed {
        logic [RSV_W-1:0]   rsv;
        logic [BUS_W-1:0]   bus;
        logic               half;
        logic [ROW_W-1:0]   row;
        logic [COL_W-1:0]   col;
        logic [MINOR_W-1:0] minor;
    } far_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_DATA = 2'd1,
        S_PAD  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/far_word_cnt.sv
module far_word_cnt #(
    parameter int WPF = 101
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_last
);
    localparam int CW = (WPF > 1) ? $clog2(WPF) : 1;

    logic [CW-1:0] cnt_q;

    assign at_last = (cnt_q == CW'(WPF - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= at_last ? '0 : cnt_q + 1'b1;
        end
    end

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(WPF - 1));
endmodule

// File: rtl/far_step.sv
module far_step
    import far_pkg::*;
#(
    parameter int COL_LAST = 9,
    parameter int ROW_LAST = 1
) (
    input  far_t               cur,
    input  logic [MINOR_W-1:0] frames,
    output far_t               nxt,
    output logic               row_end
);
    always_comb begin
        nxt     = cur;
        row_end = 1'b0;
        if ({1'b0, cur.minor} + 8'd1 >= {1'b0, frames}) begin
            nxt.minor = '0;
            if (cur.col >= COL_W'(COL_LAST)) begin
                nxt.col = '0;
                row_end = 1'b1;
                if (cur.row >= ROW_W'(ROW_LAST)) begin
                    nxt.row  = '0;
                    nxt.half = ~cur.half;
                end else begin
                    nxt.row = cur.row + 1'b1;
                end
            end else begin
                nxt.col = cur.col + 1'b1;
            end
        end else begin
            nxt.minor = cur.minor + 1'b1;
        end
    end
endmodule

// File: rtl/frame_addr_seq.sv
module frame_addr_seq
    import far_pkg::*;
#(
    parameter int WORDS_PER_FRAME = 101,
    parameter int PAD_FRAMES      = 2,
    parameter int COL_LAST        = 9,
    parameter int ROW_LAST        = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               far_wr,
    input  logic [31:0]        far_wdata,
    input  logic               data_vld,
    input  logic               data_last,
    input  logic               autoinc_off,
    output logic [IDX_W-1:0]   cnt_idx,
    input  logic [MINOR_W-1:0] cnt_frames,
    output logic               frame_done,
    output logic [31:0]        frame_addr,
    output logic               expect_pad,
    output logic               short_err
);
    localparam int PW = $clog2(PAD_FRAMES) + 1;

    seq_state_e    state_q, state_d;
    far_t          addr_q, nxt_addr;
    logic          row_end, at_last, accept, done, pad_last;
    logic [PW-1:0] pad_cnt_q;
    logic          past_ok;

    assign frame_addr = addr_q;
    assign cnt_idx    = {addr_q.bus, addr_q.col};
    assign accept     = data_vld && !far_wr && (state_q != S_IDLE);
    assign done       = accept && at_last;
    assign pad_last   = (pad_cnt_q == PW'(PAD_FRAMES - 1));

    far_word_cnt #(.WPF(WORDS_PER_FRAME)) u_words (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (far_wr),
        .inc     (accept),
        .at_last (at_last)
    );

    far_step #(.COL_LAST(COL_LAST), .ROW_LAST(ROW_LAST)) u_step (
        .cur     (addr_q),
        .frames  (cnt_frames),
        .nxt     (nxt_addr),
        .row_end (row_end)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (far_wr) state_d = S_DATA;
            S_DATA: begin
                if (far_wr)                                 state_d = S_DATA;
                else if (done && !autoinc_off && row_end)   state_d = S_PAD;
            end
            S_PAD: begin
                if (far_wr)                 state_d = S_DATA;
                else if (done && pad_last)  state_d = S_DATA;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (far_wr) begin
            addr_q <= far_t'(far_wdata);
        end else if (state_q == S_DATA && done && !autoinc_off) begin
            addr_q <= nxt_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || far_wr || state_q != S_PAD) pad_cnt_q <= '0;
        else if (done)                            pad_cnt_q <= pad_cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_done <= 1'b0;
            expect_pad <= 1'b0;
            short_err  <= 1'b0;
        end else begin
            frame_done <= done;
            expect_pad <= (state_d == S_PAD);
            if (far_wr)                              short_err <= 1'b0;
            else if (accept && data_last && !at_last) short_err <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |=> !frame_done);

    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(far_wr)) |-> (frame_addr == $past(far_wdata)));

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R7
    pad_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(expect_pad)) |-> frame_done);

    // R7
    pad_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $fell(expect_pad)) |-> (frame_done || $past(far_wr)));

    // R8
    hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && frame_done && $past(autoinc_off)) |-> $stable(frame_addr));

    // R9
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(short_err)) |-> $past(data_vld && data_last));
endmodule

// File: tb/frame_addr_seq_test.sv
`timescale 1ns/1ps
module frame_addr_seq_test;
    localparam int WPF  = 101;
    localparam int PADN = 2;
    localparam int CL   = 3;
    localparam int RL   = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        far_wr = 1'b0;
    logic [31:0] far_wdata = '0;
    logic        data_vld = 1'b0;
    logic        data_last = 1'b0;
    logic        autoinc_off = 1'b0;
    logic [12:0] cnt_idx;
    logic [6:0]  cnt_frames;
    logic        frame_done, expect_pad, short_err;
    logic [31:0] frame_addr;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [31:0] maddr;
    int          mw;
    int          mpad;
    bit          merr;

    always #4 clk = ~clk;

    frame_addr_seq #(.WORDS_PER_FRAME(WPF), .PAD_FRAMES(PADN),
                     .COL_LAST(CL), .ROW_LAST(RL)) uut (
        .clk(clk), .rst_n(rst_n), .far_wr(far_wr), .far_wdata(far_wdata),
        .data_vld(data_vld), .data_last(data_last), .autoinc_off(autoinc_off),
        .cnt_idx(cnt_idx), .cnt_frames(cnt_frames), .frame_done(frame_done),
        .frame_addr(frame_addr), .expect_pad(expect_pad), .short_err(short_err)
    );

    function automatic logic [6:0] f_frames(logic [9:0] col);
        return 7'((col % 3) + 2);
    endfunction

    always_comb cnt_frames = f_frames(cnt_idx[9:0]);

    function automatic logic [32:0] f_next(logic [31:0] a);
        logic [6:0] mi = a[6:0];
        logic [9:0] co = a[16:7];
        logic [4:0] ro = a[21:17];
        logic       hf = a[22];
        logic       wrap = 1'b0;
        if (int'(mi) + 1 >= int'(f_frames(co))) begin
            mi = '0;
            if (int'(co) >= CL) begin
                co = '0;
                wrap = 1'b1;
                if (int'(ro) >= RL) begin ro = '0; hf = ~hf; end
                else ro = ro + 1'b1;
            end else co = co + 1'b1;
        end else mi = mi + 1'b1;
        return {wrap, a[31:23], hf, ro, co, mi};
    endfunction

    function automatic logic [31:0] mk(int rsv, int bus, int half, int row, int col, int minor);
        return {6'(rsv), 3'(bus), 1'(half), 5'(row), 10'(col), 7'(minor)};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load(logic [31:0] a, bit with_word);
        @(negedge clk);
        far_wr = 1'b1; far_wdata = a; data_vld = with_word;
        @(negedge clk);
        far_wr = 1'b0; data_vld = 1'b0;
        maddr = a; mw = 0; mpad = 0; merr = 0;
        chk("R2 load address", frame_addr, a);
        chk("R9 load clears error", 32'(short_err), 32'd0);
    endtask

    task automatic run(int n, bit last);
        bit exp_done = 0;
        logic [32:0] r;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            data_vld = 1'b1;
            data_last = last && (i == n - 1);
        end
        @(negedge clk);
        data_vld = 1'b0; data_last = 1'b0;
        for (int i = 0; i < n; i++) begin
            mw++;
            if (last && i == n - 1 && mw != WPF) merr = 1;
            if (mw == WPF) begin
                mw = 0;
                if (i == n - 1) exp_done = 1;
                if (mpad > 0) mpad--;
                else if (!autoinc_off) begin
                    r = f_next(maddr);
                    maddr = r[31:0];
                    if (r[32]) mpad = PADN;
                end
            end
        end
        chk("R3 frame_done", 32'(frame_done), 32'(exp_done));
        chk("R4 R5 R6 address", frame_addr, maddr);
        chk("R7 expect_pad", 32'(expect_pad), 32'(mpad > 0));
        chk("R9 short_err", 32'(short_err), 32'(merr));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int pulses;
        void'($urandom(32'h1f2e3d4c));
        maddr = '0; mw = 0; mpad = 0; merr = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset addr", frame_addr, 32'd0);
        chk("R1 reset done", 32'(frame_done), 32'd0);
        chk("R1 reset pad", 32'(expect_pad), 32'd0);
        chk("R1 reset err", 32'(short_err), 32'd0);
        rst_n = 1'b1;
        // R1 words before any load are ignored
        pulses = 0;
        for (int i = 0; i < WPF + 3; i++) begin
            @(negedge clk);
            data_vld = 1'b1;
            pulses += int'(frame_done);
        end
        @(negedge clk); data_vld = 1'b0; pulses += int'(frame_done);
        @(negedge clk); pulses += int'(frame_done);
        chk("R1 idle words ignored", 32'(pulses), 32'd0);
        chk("R1 idle address", frame_addr, 32'd0);

        // R2 load with a coincident word: the word is dropped
        load(mk(42, 1, 0, 0, 0, 0), 1'b1);
        run(WPF - 1, 0);
        chk("R2 dropped word", 32'(frame_done), 32'd0);
        run(1, 0);
        chk("R4 minor step", frame_addr, mk(42, 1, 0, 0, 0, 1));

        // R4 R5 column wrap into next row with filler frames (R7)
        load(mk(5, 2, 0, 0, CL, 1), 1'b0);
        run(WPF, 0);
        chk("R5 row step", frame_addr, mk(5, 2, 0, 1, 0, 0));
        chk("R7 pad raised", 32'(expect_pad), 32'd1);
        run(WPF, 0);
        run(WPF, 0);
        chk("R7 pad done", 32'(expect_pad), 32'd0);
        run(WPF, 0);

        // R6 half toggles at last row
        load(mk(0, 7, 0, RL, CL, 1), 1'b0);
        run(WPF, 0);
        chk("R6 half toggle", frame_addr, mk(0, 7, 1, 0, 0, 0));

        // R8 hold address, and no filler at a wrap point
        load(mk(1, 3, 1, RL, CL, 1), 1'b0);
        autoinc_off = 1'b1;
        run(WPF, 0);
        run(WPF, 0);
        chk("R8 held address", frame_addr, mk(1, 3, 1, RL, CL, 1));
        chk("R8 no pad", 32'(expect_pad), 32'd0);
        autoinc_off = 1'b0;

        // R9 short final frame, sticky, then cleared
        load(mk(0, 0, 0, 0, 1, 0), 1'b0);
        run(50, 1);
        chk("R9 short raised", 32'(short_err), 32'd1);
        run(WPF, 0);
        chk("R9 sticky", 32'(short_err), 32'd1);
        load(mk(0, 0, 0, 0, 2, 0), 1'b0);
        run(WPF, 1);
        chk("R9 full frame ok", 32'(short_err), 32'd0);

        // Random mix
        for (int it = 0; it < 60; it++) begin
            int n;
            if ($urandom % 10 == 0) begin
                int col = int'($urandom % (CL + 1));
                load(mk(int'($urandom % 64), int'($urandom % 8), int'($urandom % 2),
                        int'($urandom % (RL + 1)), col,
                        int'($urandom % f_frames(10'(col)))), 1'b0);
            end
            autoinc_off = ($urandom % 8 == 0);
            n = ($urandom % 4 == 0) ? int'(1 + $urandom % (WPF - 1)) : WPF - mw;
            run(n, ($urandom % 6 == 0));
        end
        autoinc_off = 1'b0;

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule